// File: doc/BRIEF.md
# Byte-Parallel CRC-16 Frame Check Generator

This block produces the 16-bit frame check value for one frame at a time. Bytes arrive one per clock under a valid strobe. Each accepted byte moves the CRC state forward by eight single-bit steps within that one clock. A fixed number of leading bytes per frame carry the preamble and start delimiter, and these bytes are counted and left out of the computation.

When the valid strobe drops, the block inverts the CRC state and sends it out one bit per clock, least significant bit first, under its own valid strobe. The same value is also held on a 16-bit parallel port. Any byte that arrives during the serial phase is refused and raises a busy flag. From the clock after the last check bit, the block accepts a new frame that starts from a fresh state.

Top module: `crc16_fcs_gen`

## Requirements
- R1: While reset is asserted and after it is released, `fcs_vld_o`, `busy_o` and `fcs_o` are all 0.
- R2: The CRC state resets to 0xFFFF. Each input bit d applies one step with feedback f = state[0]^d: the state shifts right, new bit 15 = f, new bit 10 = old bit 11 ^ f, new bit 3 = old bit 4 ^ f. Bits of a byte are applied from bit 0 up to bit 7. The check value is the bitwise inverse of the state (for the ASCII payload "123456789" it is 0x906E).
- R3: The first SKIP_BYTES (default 10) valid bytes of each frame are counted but have no effect on the check value.
- R4: In the first clock edge where `byte_vld_i` is low after a frame has started, the check value is loaded. In the next 16 cycles `fcs_vld_o` is 1 and `fcs_bit_o` carries check bit k in the k-th of those cycles (k = 0 first). After that, `fcs_vld_o` returns to 0.
- R5: `fcs_o` holds the whole check value from the first serial cycle until the next frame loads a new value.
- R6: A byte presented while `fcs_vld_o` is 1 is not absorbed and does not start a frame, and `busy_o` is 1 in that cycle.
- R7: A byte presented in the cycle right after the 16th check bit starts a new frame, and that frame's state starts from 0xFFFF.
- R8: A frame that holds only the SKIP_BYTES leading bytes yields a check value of 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_i | input | 8 | Frame byte |
| byte_vld_i | input | 1 | Byte valid; a low level ends the frame |
| fcs_bit_o | output | 1 | Serial check bit, LSB first |
| fcs_vld_o | output | 1 | Serial check bit valid |
| fcs_o | output | 16 | Last check value, parallel |
| busy_o | output | 1 | A byte was refused this cycle |

## Verification
Two events can fall in the same cycle: the serializer sending a check bit, and a new byte arriving at the input. The bench provokes this by presenting bytes in the middle of the serial phase and on the 16th bit, where the serializer is finishing its frame and the controller could take the byte as the start of a new one. A refused byte is judged by three things: `busy_o` rises in that cycle, no extra serial burst follows, and the next frame's check value matches the model. A frame started in the cycle right after the 16th bit is judged against a fresh reference computation, which proves the state was re-initialised.

// File: rtl/crc16_fcs_pkg.sv
package crc16_fcs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RECV = 2'd1,
    ST_SEND = 2'd2
  } fr_state_e;
endpackage

// File: rtl/crc16_byte_step.sv
module crc16_byte_step #(
  parameter int          DATA_W = 8,
  parameter int          CRC_W  = 16,
  parameter logic [15:0] POLY   = 16'h8408
) (
  input  logic [CRC_W-1:0]  crc_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o
);
  logic [DATA_W:0][CRC_W-1:0] chain;
  assign chain[0] = crc_i;

  // one reflected LFSR step per data bit, LSB applied first
  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    logic fb;
    assign fb           = chain[g][0] ^ data_i[g];
    assign chain[g+1]   = (chain[g] >> 1) ^ ({CRC_W{fb}} & POLY[CRC_W-1:0]);
  end

  assign crc_o = chain[DATA_W];
endmodule

// File: rtl/crc16_frame_ctrl.sv
module crc16_frame_ctrl
  import crc16_fcs_pkg::*;
#(
  parameter int SKIP_BYTES = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic byte_vld_i,
  input  logic send_done_i,
  output logic absorb_o,
  output logic load_o,
  output logic in_frame_o,
  output logic busy_o
);
  localparam int SK_W = $clog2(SKIP_BYTES + 2);
  localparam logic [SK_W-1:0] SKIP_N = SK_W'(SKIP_BYTES);

  fr_state_e       state_q;
  logic [SK_W-1:0] skip_cnt_q;
  logic            accept;

  assign accept     = byte_vld_i && (state_q != ST_SEND);
  assign absorb_o   = accept && (skip_cnt_q == SKIP_N);
  assign load_o     = (state_q == ST_RECV) && !byte_vld_i;
  assign in_frame_o = (state_q == ST_RECV);
  assign busy_o     = byte_vld_i && (state_q == ST_SEND);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      skip_cnt_q <= '0;
    end else begin
      if (accept && !absorb_o) skip_cnt_q <= skip_cnt_q + 1'b1;
      else if (load_o)         skip_cnt_q <= '0;
      unique case (state_q)
        ST_IDLE: if (accept)       state_q <= ST_RECV;
        ST_RECV: if (load_o)       state_q <= ST_SEND;
        ST_SEND: if (send_done_i)  state_q <= ST_IDLE;
        default:                   state_q <= ST_IDLE;
      endcase
    end
  end

  AST_SKIP_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_cnt_q <= SKIP_N); // R3
  AST_IDLE_NO_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> (skip_cnt_q == '0)); // R7
endmodule

// File: rtl/crc16_serializer.sv
module crc16_serializer #(
  parameter int CRC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CRC_W-1:0] val_i,
  output logic             bit_o,
  output logic             vld_o,
  output logic             done_o,
  output logic [CRC_W-1:0] word_o
);
  localparam int              CNT_W = $clog2(CRC_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CRC_W - 1);

  logic [CRC_W-1:0] sreg_q, hold_q;
  logic [CNT_W-1:0] cnt_q;
  logic             act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
      hold_q <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
    end else if (load_i) begin
      sreg_q <= val_i;
      hold_q <= val_i;
      cnt_q  <= '0;
      act_q  <= 1'b1;
    end else if (act_q) begin
      sreg_q <= sreg_q >> 1;
      cnt_q  <= cnt_q + 1'b1;
      if (cnt_q == LAST) act_q <= 1'b0;
    end
  end

  assign bit_o  = sreg_q[0];
  assign vld_o  = act_q;
  assign done_o = act_q && (cnt_q == LAST);
  assign word_o = hold_q;

  AST_LOAD_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !act_q); // R7
endmodule

// File: rtl/crc16_fcs_gen.sv
module crc16_fcs_gen #(
  parameter int          DATA_W     = 8,
  parameter int          CRC_W      = 16,
  parameter logic [15:0] POLY       = 16'h8408,
  parameter logic [15:0] INIT       = 16'hFFFF,
  parameter int          SKIP_BYTES = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              byte_vld_i,
  output logic              fcs_bit_o,
  output logic              fcs_vld_o,
  output logic [CRC_W-1:0]  fcs_o,
  output logic              busy_o
);
  localparam logic [CRC_W-1:0] INIT_V = INIT[CRC_W-1:0];

  logic [CRC_W-1:0] crc_q, crc_nxt;
  logic absorb, load, in_frame, send_done;

  crc16_frame_ctrl #(.SKIP_BYTES(SKIP_BYTES)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .byte_vld_i  (byte_vld_i),
    .send_done_i (send_done),
    .absorb_o    (absorb),
    .load_o      (load),
    .in_frame_o  (in_frame),
    .busy_o      (busy_o)
  );

  crc16_byte_step #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(POLY)) u_step (
    .crc_i  (crc_q),
    .data_i (byte_i),
    .crc_o  (crc_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        crc_q <= INIT_V;
    else if (absorb)    crc_q <= crc_nxt;
    else if (send_done) crc_q <= INIT_V;
  end

  crc16_serializer #(.CRC_W(CRC_W)) u_ser (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .val_i  (~crc_q),
    .bit_o  (fcs_bit_o),
    .vld_o  (fcs_vld_o),
    .done_o (send_done),
    .word_o (fcs_o)
  );

  AST_SEND_ON_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_frame && !byte_vld_i) |=> fcs_vld_o); // R4
  AST_FIRST_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fcs_vld_o && !$past(fcs_vld_o)) |-> (fcs_bit_o == fcs_o[0])); // R4
  AST_NO_ABSORB_SEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fcs_vld_o |-> !absorb); // R6
  AST_BUSY_IN_SEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> fcs_vld_o); // R6
  AST_WORD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fcs_vld_o && $past(fcs_vld_o)) |-> $stable(fcs_o)); // R5
  AST_FRESH_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_frame && !fcs_vld_o) |-> (crc_q == INIT_V)); // R7
endmodule

// File: tb/crc16_fcs_gen_tb.sv
module crc16_fcs_gen_tb;
  localparam int SKIP = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [7:0]  byte_i;
  logic        byte_vld_i;
  logic        fcs_bit_o, fcs_vld_o, busy_o;
  logic [15:0] fcs_o;

  always #2 clk_i = ~clk_i;

  crc16_fcs_gen u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .byte_i(byte_i), .byte_vld_i(byte_vld_i),
    .fcs_bit_o(fcs_bit_o), .fcs_vld_o(fcs_vld_o), .fcs_o(fcs_o), .busy_o(busy_o)
  );

  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;
  logic [7:0]  fbuf [0:63];
  logic [31:0] seed = 32'h1234_5678;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed[23:16];
  endfunction

  function automatic logic [15:0] ref_fcs(input int len);
    logic [15:0] s = 16'hFFFF;
    for (int i = SKIP; i < len; i++)
      for (int b = 0; b < 8; b++) begin
        logic d = fbuf[i][b];
        s = {s[0]^d, s[15:12], s[11]^s[0]^d, s[10:5], s[4]^s[0]^d, s[3:1]};
      end
    return ~s;
  endfunction

  // entered and left at a negedge; first byte driven at once (back-to-back capable)
  task automatic play(input int len, input int inject_at, input string tag, input logic [15:0] exp);
    for (int i = 0; i < len; i++) begin
      if (i != 0) @(negedge clk_i);
      byte_i = fbuf[i]; byte_vld_i = 1'b1;
    end
    @(negedge clk_i);
    byte_vld_i = 1'b0; byte_i = 8'h00;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk_i);
      byte_vld_i = 1'b0;
      chk("R4 vld", {31'd0, fcs_vld_o}, 32'd1);
      chk("R4 bit", {31'd0, fcs_bit_o}, {31'd0, exp[k]});
      chk({tag, " word"}, {16'd0, fcs_o}, {16'd0, exp});
      if (k == inject_at) begin
        byte_i = rnd(); byte_vld_i = 1'b1;
        #1 chk("R6 busy", {31'd0, busy_o}, 32'd1);
      end
    end
    @(negedge clk_i);
    byte_vld_i = 1'b0;
    chk("R4 end", {31'd0, fcs_vld_o}, 32'd0);
    chk("R6 idle", {31'd0, busy_o}, 32'd0);
    if (inject_at >= 0) begin
      @(negedge clk_i);
      chk("R6 nostart", {31'd0, fcs_vld_o}, 32'd0);
      chk("R5 hold", {16'd0, fcs_o}, {16'd0, exp});
    end
  endtask

  initial begin
    rst_ni = 1'b0; byte_vld_i = 1'b0; byte_i = 8'h00;
    @(negedge clk_i); @(negedge clk_i);
    chk("R1 vld", {31'd0, fcs_vld_o}, 32'd0);
    chk("R1 busy", {31'd0, busy_o}, 32'd0);
    chk("R1 word", {16'd0, fcs_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 post", {31'd0, fcs_vld_o}, 32'd0);

    // R2 known vector behind a random preamble
    for (int i = 0; i < SKIP; i++) fbuf[i] = rnd();
    for (int i = 0; i < 9; i++) fbuf[SKIP+i] = 8'h31 + 8'(i);
    chk("R2 model", {16'd0, ref_fcs(SKIP+9)}, 32'h906E);
    play(SKIP+9, -1, "R2", 16'h906E);

    // R3 same payload, different preamble: same value
    for (int i = 0; i < SKIP; i++) fbuf[i] = ~fbuf[i];
    play(SKIP+9, -1, "R3", 16'h906E);

    // R8 preamble only
    @(negedge clk_i);
    for (int i = 0; i < SKIP; i++) fbuf[i] = rnd();
    chk("R8 model", {16'd0, ref_fcs(SKIP)}, 32'd0);
    play(SKIP, -1, "R8", 16'h0000);

    // R7 back-to-back sweep of payload lengths with random data
    for (int len = SKIP + 1; len <= SKIP + 40; len++) begin
      for (int i = 0; i < len; i++) fbuf[i] = rnd();
      play(len, -1, "R7", ref_fcs(len));
    end

    // constant payloads
    for (int i = 0; i < 32; i++) fbuf[i] = (i < SKIP) ? rnd() : 8'h00;
    play(32, -1, "R2 zeros", ref_fcs(32));
    for (int i = SKIP; i < 32; i++) fbuf[i] = 8'hFF;
    play(32, -1, "R2 ones", ref_fcs(32));

    // R6 refused bytes mid-shift and on the last bit, then a clean frame
    for (int i = 0; i < 20; i++) fbuf[i] = rnd();
    play(20, 3, "R6 mid", ref_fcs(20));
    play(20, 15, "R6 last", ref_fcs(20));
    play(20, -1, "R6 after", ref_fcs(20));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule